// File: doc/BRIEF.md
# Single-Bus Datapath Core with Hardwired Step Sequencer

This block is a small processor core in which every transfer between storage elements goes over one shared internal bus. It contains a bank of general registers, a program counter, an instruction register, a memory address register, a memory data register and an ALU. The ALU is staged by two registers: a Y register that feeds the ALU A input, and a Z register that captures the ALU result. A hardwired control-step counter, together with a decoder, raises per-register load and drive strobes each cycle. The decoder is built so that no more than one source drives the bus at a time.

Every instruction starts with a three-step fetch. The fetch reads the word at the program counter and advances the counter by 4 through the ALU's constant input. A short execute sequence follows, chosen by the opcode, and its last step raises an end strobe that sends the counter back to the first fetch step. Memory is reached through a registered byte address, a read strobe and a completion flag. Any step that waits for memory holds the step counter until the completion flag arrives, so the memory may take any number of cycles.

Top module: `sbus_core`

## Requirements
- R1: While `rst` is high at a clock edge, the step counter returns to step index 0, the program counter and `mem_read` clear to 0, and `bus_mon` reads 0 because the program counter drives it in step index 0. `step_mon` is the zero-based step index, so 0 means the first fetch step.
- R2: The fetch reads memory at the program counter, loads the instruction register, and advances the program counter by exactly 4 per instruction. At step index 0 `bus_mon` shows the address of the instruction being fetched: 0, 4, 8 and so on.
- R3: A wait step holds the step counter while `mem_mfc` is low. With a memory that raises `mem_mfc` L cycles after the read begins, each wait step lasts 1+L cycles. From step index 0 to the end step, inclusive, the instruction lengths are: a move takes 4+L cycles, an ALU operation 6+L, an add-from-memory 7+2L, and an unused opcode 4+L.
- R4: Opcode 0 (move) copies register ra into register rd. The instruction word is split into opcode bits [12:9], rd [8:6], ra [5:3] and rb [2:0]; bits [31:13] are ignored. In the end step `bus_mon` carries the moved value.
- R5: Opcodes 1, 2 and 3 write rd with ra+rb, ra−rb and ra XOR rb respectively, modulo 2^32. The result appears on `bus_mon` in the end step.
- R6: Opcode 4 (add from memory) writes rd with rd plus the memory word at the byte address held in ra. It issues a read with `mem_addr` equal to ra, and holds `mem_addr` and `mem_read` steady until `mem_mfc` is seen.
- R7: No more than one source drives the bus in any cycle. In a step where nothing drives it, the bus reads 0.
- R8: The cycle after the end strobe `instr_end`, the step counter is back at step index 0.
- R9: Opcodes 5 to 15 change no register. They end in step index 3, and the bus is undriven in that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address held in the memory address register |
| mem_read | output | 1 | Read request, high from issue until completion is seen |
| mem_rdata | input | 32 | Read data, captured when `mem_mfc` is high during a read |
| mem_mfc | input | 1 | Memory completion flag |
| bus_mon | output | 32 | Value on the internal bus this cycle |
| step_mon | output | 3 | Current zero-based control step index |
| instr_end | output | 1 | High in the last step of every instruction |

## Verification
The bench builds the core with its default parameters: 32-bit words, 8 general registers, a 4-bit opcode, and a bank that clears on reset. This gives a 13-bit instruction field, so the upper 19 bits of every program word can hold data. Because the bank clears on reset, an add-from-memory into a zero register works as a load. The bench runs with memory latencies of 0, 1 and 3 cycles. These bring both wait steps, the wrap of subtraction below zero, the case where the destination register is also the address register, and an undriven-bus step within reach.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_XOR = 2'd2
   } alu_op_e;

   localparam int NUM_STEPS = 7;
   localparam int STW       = $clog2(NUM_STEPS);

   localparam int OPC_MOV  = 0;
   localparam int OPC_ADD  = 1;
   localparam int OPC_SUB  = 2;
   localparam int OPC_XOR  = 3;
   localparam int OPC_ADDM = 4;
endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
   import sbus_pkg::*;
#(
   parameter int NREG = 8,
   parameter int OPW  = 4,
   localparam int RW  = $clog2(NREG),
   localparam int IW  = OPW + 3 * RW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [IW-1:0]   ir,
   input  logic            mfc,
   output logic [STW-1:0]  step,
   output logic [NREG-1:0] gpr_in,
   output logic [NREG-1:0] gpr_out,
   output logic            pc_in,
   output logic            pc_out,
   output logic            mar_in,
   output logic            rd_start,
   output logic            mdr_out,
   output logic            ir_in,
   output logic            y_in,
   output logic            z_in,
   output logic            z_out,
   output logic            sel4,
   output alu_op_e         alu_op,
   output logic            wmfc,
   output logic            fin
);
   logic [OPW-1:0] op;
   logic [RW-1:0]  rd, ra, rb;
   logic           is_alu, is_mov, is_addm;

   assign op = ir[IW-1 -: OPW];
   assign rd = ir[3*RW-1 -: RW];
   assign ra = ir[2*RW-1 -: RW];
   assign rb = ir[RW-1:0];

   assign is_mov  = (op == OPW'(OPC_MOV));
   assign is_addm = (op == OPW'(OPC_ADDM));
   assign is_alu  = (op == OPW'(OPC_ADD)) || (op == OPW'(OPC_SUB)) ||
                    (op == OPW'(OPC_XOR));

   // step counter: wrap on end, hold on an unanswered wait
   always_ff @(posedge clk) begin
      if (rst)
         step <= '0;
      else if (fin)
         step <= '0;
      else if (!(wmfc && !mfc))
         step <= step + 1'b1;
   end

   always_comb begin
      gpr_in   = '0;
      gpr_out  = '0;
      pc_in    = 1'b0;
      pc_out   = 1'b0;
      mar_in   = 1'b0;
      rd_start = 1'b0;
      mdr_out  = 1'b0;
      ir_in    = 1'b0;
      y_in     = 1'b0;
      z_in     = 1'b0;
      z_out    = 1'b0;
      sel4     = 1'b0;
      alu_op   = ALU_ADD;
      wmfc     = 1'b0;
      fin      = 1'b0;
      case (step)
         STW'(0): begin
            pc_out = 1'b1; mar_in = 1'b1; rd_start = 1'b1;
            sel4 = 1'b1; z_in = 1'b1;
         end
         STW'(1): begin
            z_out = 1'b1; pc_in = 1'b1; y_in = 1'b1; wmfc = 1'b1;
         end
         STW'(2): begin
            mdr_out = 1'b1; ir_in = 1'b1;
         end
         STW'(3): begin
            if (is_mov) begin
               gpr_out[ra] = 1'b1; gpr_in[rd] = 1'b1; fin = 1'b1;
            end else if (is_alu) begin
               gpr_out[ra] = 1'b1; y_in = 1'b1;
            end else if (is_addm) begin
               gpr_out[ra] = 1'b1; mar_in = 1'b1; rd_start = 1'b1;
            end else begin
               fin = 1'b1;
            end
         end
         STW'(4): begin
            if (is_alu) begin
               gpr_out[rb] = 1'b1; z_in = 1'b1;
               case (op)
                  OPW'(OPC_SUB): alu_op = ALU_SUB;
                  OPW'(OPC_XOR): alu_op = ALU_XOR;
                  default:       alu_op = ALU_ADD;
               endcase
            end else if (is_addm) begin
               gpr_out[rd] = 1'b1; y_in = 1'b1; wmfc = 1'b1;
            end else begin
               fin = 1'b1;
            end
         end
         STW'(5): begin
            if (is_alu) begin
               z_out = 1'b1; gpr_in[rd] = 1'b1; fin = 1'b1;
            end else if (is_addm) begin
               mdr_out = 1'b1; z_in = 1'b1;
            end else begin
               fin = 1'b1;
            end
         end
         STW'(6): begin
            if (is_addm) begin
               z_out = 1'b1; gpr_in[rd] = 1'b1;
            end
            fin = 1'b1;
         end
         default: fin = 1'b1;
      endcase
   end
endmodule

// File: rtl/sbus_gpr.sv
module sbus_gpr #(
   parameter int DW      = 32,
   parameter int NREG    = 8,
   parameter bit CLR_RST = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [DW-1:0]   bus_in,
   input  logic [NREG-1:0] load,
   input  logic [NREG-1:0] drive,
   output logic [DW-1:0]   bus_part
);
   logic [NREG-1:0][DW-1:0] part;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] q;
      if (CLR_RST) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (load[i])
               q <= bus_in;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (load[i])
               q <= bus_in;
         end
         logic unused_rst;
         assign unused_rst = rst;
      end
      assign part[i] = drive[i] ? q : '0;
   end

   always_comb begin
      bus_part = '0;
      for (int i = 0; i < NREG; i++)
         bus_part = bus_part | part[i];
   end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          sel4,
   input  logic [DW-1:0] y_val,
   input  logic [DW-1:0] b_val,
   input  alu_op_e       op,
   output logic [DW-1:0] res
);
   logic [DW-1:0] a_val;

   assign a_val = sel4 ? DW'(4) : y_val;

   always_comb begin
      case (op)
         ALU_SUB: res = a_val - b_val;
         ALU_XOR: res = a_val ^ b_val;
         default: res = a_val + b_val;
      endcase
   end
endmodule

// File: rtl/sbus_core.sv
module sbus_core
   import sbus_pkg::*;
#(
   parameter int DW      = 32,
   parameter int NREG    = 8,
   parameter int OPW     = 4,
   parameter bit GPR_CLR = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   output logic [DW-1:0]  mem_addr,
   output logic           mem_read,
   input  logic [DW-1:0]  mem_rdata,
   input  logic           mem_mfc,
   output logic [DW-1:0]  bus_mon,
   output logic [STW-1:0] step_mon,
   output logic           instr_end
);
   localparam int RW = $clog2(NREG);
   localparam int IW = OPW + 3 * RW;
   localparam int NDRV = NREG + 3;

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("sbus_core: NREG must be a power of two of at least 2");
   end
   if (IW > DW) begin : g_bad_iw
      $error("sbus_core: instruction fields do not fit in a word");
   end
   if (DW < 8) begin : g_bad_dw
      $error("sbus_core: DW must be at least 8");
   end

   logic [DW-1:0]   bus, gpr_part, alu_res;
   logic [DW-1:0]   pc_q, mar_q, mdr_q, y_q, z_q;
   logic [IW-1:0]   ir_q;
   logic [NREG-1:0] gpr_in, gpr_out;
   logic            pc_in, pc_out, mar_in, rd_start, mdr_out, ir_in;
   logic            y_in, z_in, z_out, sel4, wmfc, fin;
   alu_op_e         alu_op;
   logic [NDRV-1:0] drv_vec;
   logic            wait_step;

   sbus_ctrl #(.NREG(NREG), .OPW(OPW)) u_ctrl (
      .clk(clk), .rst(rst), .ir(ir_q), .mfc(mem_mfc), .step(step_mon),
      .gpr_in(gpr_in), .gpr_out(gpr_out), .pc_in(pc_in), .pc_out(pc_out),
      .mar_in(mar_in), .rd_start(rd_start), .mdr_out(mdr_out),
      .ir_in(ir_in), .y_in(y_in), .z_in(z_in), .z_out(z_out),
      .sel4(sel4), .alu_op(alu_op), .wmfc(wmfc), .fin(fin)
   );

   sbus_gpr #(.DW(DW), .NREG(NREG), .CLR_RST(GPR_CLR)) u_gpr (
      .clk(clk), .rst(rst), .bus_in(bus), .load(gpr_in),
      .drive(gpr_out), .bus_part(gpr_part)
   );

   sbus_alu #(.DW(DW)) u_alu (
      .sel4(sel4), .y_val(y_q), .b_val(bus), .op(alu_op), .res(alu_res)
   );

   // shared bus: AND-OR of every gated source
   always_comb begin
      bus = gpr_part;
      if (pc_out)  bus = bus | pc_q;
      if (z_out)   bus = bus | z_q;
      if (mdr_out) bus = bus | mdr_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         mar_q    <= '0;
         mdr_q    <= '0;
         y_q      <= '0;
         z_q      <= '0;
         ir_q     <= '0;
         mem_read <= 1'b0;
      end else begin
         if (pc_in)  pc_q  <= bus;
         if (mar_in) mar_q <= bus;
         if (y_in)   y_q   <= bus;
         if (z_in)   z_q   <= alu_res;
         if (ir_in)  ir_q  <= bus[IW-1:0];
         if (mem_read && mem_mfc) begin
            mdr_q    <= mem_rdata;
            mem_read <= 1'b0;
         end else if (rd_start) begin
            mem_read <= 1'b1;
         end
      end
   end

   assign mem_addr  = mar_q;
   assign bus_mon   = bus;
   assign instr_end = fin;
   assign drv_vec   = {gpr_out, pc_out, z_out, mdr_out};
   assign wait_step = wmfc;
endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk
   import sbus_pkg::*;
#(
   parameter int DW   = 32,
   parameter int NREG = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [NREG+2:0]  drv_vec,
   input logic [STW-1:0]   step_mon,
   input logic             instr_end,
   input logic             wait_step,
   input logic             mem_mfc,
   input logic             mem_read,
   input logic [DW-1:0]    mem_addr,
   input logic [DW-1:0]    pc_q
);
   AST_RESET_STEP: assert property (@(posedge clk)
      rst |=> (step_mon == '0 && !mem_read && pc_q == '0)); // R1

   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      !$stable(pc_q) |-> (pc_q == $past(pc_q) + DW'(4))); // R2

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wait_step && !mem_mfc) |=> $stable(step_mon)); // R3

   AST_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
      (mem_read && !mem_mfc) |=> (mem_read && $stable(mem_addr))); // R6

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
      $onehot0(drv_vec)); // R7

   AST_END_WRAP: assert property (@(posedge clk) disable iff (rst)
      instr_end |=> (step_mon == '0)); // R8
endmodule

bind sbus_core sbus_core_chk #(.DW(DW), .NREG(NREG)) u_chk (
   .clk(clk), .rst(rst), .drv_vec(drv_vec), .step_mon(step_mon),
   .instr_end(instr_end), .wait_step(wait_step), .mem_mfc(mem_mfc),
   .mem_read(mem_read), .mem_addr(mem_addr), .pc_q(pc_q)
);

// File: tb/sbus_core_test.sv
`timescale 1ns/1ps
module sbus_core_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr, mem_rdata, bus_mon;
   logic        mem_read, mem_mfc, instr_end;
   logic [2:0]  step_mon;

   int checks = 0;
   int fails  = 0;
   int lat    = 0;
   int mcnt   = 0;

   logic [31:0] mem [64];
   logic [31:0] mr  [8];
   logic [31:0] pc_m;

   always #2.5 clk = ~clk;

   sbus_core uut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_read(mem_read),
      .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .bus_mon(bus_mon),
      .step_mon(step_mon), .instr_end(instr_end)
   );

   // memory model: completes lat cycles after the read appears
   initial begin
      mem_mfc   = 1'b0;
      mem_rdata = '0;
   end
   always @(negedge clk) begin
      if (mem_read) begin
         mem_mfc   <= (mcnt >= lat);
         mem_rdata <= mem[mem_addr[7:2]];
         mcnt      <= mcnt + 1;
      end else begin
         mem_mfc <= 1'b0;
         mcnt    <= 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(input int op, input int rd, input int ra,
                                       input int rb, input logic [15:0] hi);
      enc = {hi, 3'b000, 4'(op), 3'(rd), 3'(ra), 3'(rb)};
   endfunction

   // runs one instruction from step index 0; returns at the next step index 0
   task automatic exec_one(input string tag);
      logic [31:0] w, expv, maddr;
      int op, rd, ra, rb, cyc, expc;
      bit wr, saw_rd;
      chk("R2 fetch address on bus", bus_mon, pc_m);
      w  = mem[pc_m[7:2]];
      op = int'(w[12:9]); rd = int'(w[8:6]); ra = int'(w[5:3]); rb = int'(w[2:0]);
      wr = 1'b1;
      case (op)
         0: begin expv = mr[ra]; expc = 4 + lat; end
         1: begin expv = mr[ra] + mr[rb]; expc = 6 + lat; end
         2: begin expv = mr[ra] - mr[rb]; expc = 6 + lat; end
         3: begin expv = mr[ra] ^ mr[rb]; expc = 6 + lat; end
         4: begin expv = mr[rd] + mem[mr[ra][7:2]]; expc = 7 + 2 * lat; end
         default: begin expv = '0; expc = 4 + lat; wr = 1'b0; end
      endcase
      cyc = 1; saw_rd = 1'b0; maddr = '0;
      while (!instr_end && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (step_mon == 3'd4 && mem_read && !saw_rd) begin
            saw_rd = 1'b1;
            maddr  = mem_addr;
         end
      end
      chk(tag, bus_mon, expv);
      chk("R3 instruction length", 32'(cyc), 32'(expc));
      if (op == 4) chk("R6 read address is ra", maddr, mr[ra]);
      if (wr) mr[rd] = expv;
      pc_m = pc_m + 32'd4;
      @(negedge clk);
      chk("R8 step index after end", 32'(step_mon), 32'd0);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 step index in reset", 32'(step_mon), 32'd0);
      chk("R1 read strobe in reset", 32'(mem_read), 32'd0);
      chk("R1 bus shows cleared pc", bus_mon, 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_load;
      lat = 0;
      exec_one("R6 add-from-memory into zero register");
      exec_one("R6 add-from-memory via register address");
   endtask

   task automatic t_move;
      exec_one("R4 move result");
   endtask

   task automatic t_alu;
      exec_one("R5 add result");
      exec_one("R5 subtract with wrap");
      exec_one("R5 xor result");
   endtask

   task automatic t_stall;
      lat = 3;
      exec_one("R3 R6 add-from-memory rd equals ra under stall");
   endtask

   task automatic t_unused;
      lat = 0;
      exec_one("R7 R9 unused opcode leaves bus undriven");
      exec_one("R9 R4 register untouched by unused opcode");
   endtask

   task automatic t_tail;
      exec_one("R5 add into register zero");
      lat = 1;
      exec_one("R4 move from register zero");
      exec_one("R6 add-from-memory latency one");
   endtask

   initial begin
      #(5.0 * 20000);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 16; i < 24; i++) mem[i] = 32'h1357_9BDF + 32'(i) * 32'h0101_0F0F;
      mem[0]  = enc(4, 1, 0, 0, 16'h0000);
      mem[1]  = enc(4, 2, 1, 0, 16'h0000);
      mem[2]  = enc(0, 4, 2, 0, 16'hABCD);
      mem[3]  = enc(1, 5, 1, 2, 16'h0000);
      mem[4]  = enc(2, 6, 1, 2, 16'h0000);
      mem[5]  = enc(3, 7, 5, 6, 16'h0000);
      mem[6]  = enc(4, 4, 4, 0, 16'h0000);
      mem[7]  = enc(15, 1, 1, 1, 16'hFFFF);
      mem[8]  = enc(0, 3, 1, 0, 16'h0000);
      mem[9]  = enc(1, 0, 7, 7, 16'h0000);
      mem[10] = enc(0, 3, 0, 0, 16'h0000);
      mem[11] = enc(4, 3, 6, 0, 16'h0000);
      for (int i = 0; i < 8; i++) mr[i] = '0;
      pc_m = '0;
      t_reset;
      t_load;
      t_move;
      t_alu;
      t_stall;
      t_unused;
      t_tail;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule